// File: doc/BRIEF.md
# Power-Up Event Qualifier

This block sits in the always-on domain of a power controller and decides when a system that is switched off should start up. It watches four wake sources: a charger-present detector, a USB bus-voltage detector, a battery comparator that reports whether the battery is above its low-battery threshold, and an alarm match between a running time-of-day/day counter pair and their programmed alarm values. A fifth source, a restart request, can be enabled or disabled by its own control bit.

Every source is edge-detected. The battery comparator is a wake source in its own right when it rises. It also qualifies all other sources: they can wake the system only while the battery is good. When a qualified event arrives while the system is off, the block emits a one-cycle turn-on request. It records the winning source in a code register, using a fixed priority order. The charger and USB detectors each also have a sticky interrupt flag, cleared by writing one, and a live sense bit.

The three comparator and detector inputs are asynchronous and pass through two-flop synchronisers. The alarm values and the restart request are already synchronous to the clock.

Top module: `wake_qualifier`

## Requirements
- R1: A rising edge on `chg_det_a` sets `chg_irq`, which stays set after the pin falls. `chg_sense` follows the pin level, delayed by the synchroniser.
- R2: A rising edge on `usb_det_a` sets `usb_irq`, which stays set after the pin falls. `usb_sense` follows the pin level, delayed by the synchroniser.
- R3: Writing 1 to `irq_clr` bit 0 clears `chg_irq`, and writing 1 to bit 1 clears `usb_irq`. If a clear arrives in the same cycle as a new set, the flag stays set.
- R4: Charger, USB, alarm and restart events cause a turn-on only while the synchronised battery comparator is high. The interrupt flags are set regardless of the battery level.
- R5: A rising edge on `batt_ok_a` is a wake event.
- R6: An alarm event is the cycle in which both `tod_cnt == tod_alarm` and `day_cnt == day_alarm` first become true. A match on only one of the two pairs has no effect.
- R7: A rising edge on `restart_req` is a wake event only while `restart_en` is 1. Otherwise it is ignored.
- R8: `turn_on` is a pulse one cycle wide, issued only while `sys_off` was 1 in the preceding cycle. An event that arrives while `sys_off` is 0 produces no pulse and leaves `wake_src` unchanged.
- R9: On each pulse, `wake_src` captures the highest-priority simultaneous event, using these codes: battery=1 (highest), charger=2, USB=3, alarm=4, restart=5 (lowest). It holds that value between pulses.
- R10: After reset, `turn_on`, `wake_src`, `chg_irq` and `usb_irq` are 0. A change on an asynchronous input sampled at clock edge k gives `turn_on` high after edge k+2. A synchronous alarm or restart change sampled at edge k gives `turn_on` high after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chg_det_a | input | 1 | Charger-present detector, asynchronous |
| usb_det_a | input | 1 | USB bus-voltage-present detector, asynchronous |
| batt_ok_a | input | 1 | Battery-above-threshold comparator, asynchronous |
| tod_cnt | input | TOD_W | Current time-of-day count |
| tod_alarm | input | TOD_W | Programmed time-of-day alarm |
| day_cnt | input | DAY_W | Current day count |
| day_alarm | input | DAY_W | Programmed day alarm |
| restart_req | input | 1 | Restart request, synchronous |
| restart_en | input | 1 | Enables restart as a wake source |
| sys_off | input | 1 | System state is off |
| irq_clr | input | 2 | Write-1-to-clear strobes: bit 0 clears the charger flag, bit 1 clears the USB flag |
| chg_irq | output | 1 | Sticky charger interrupt flag |
| usb_irq | output | 1 | Sticky USB interrupt flag |
| chg_sense | output | 1 | Live charger level, synchronised |
| usb_sense | output | 1 | Live USB level, synchronised |
| turn_on | output | 1 | One-cycle turn-on request |
| wake_src | output | 3 | Code of the source that caused the last turn-on |

## Verification
An asynchronous pin change driven on a falling edge is sampled at the next rising edge (edge k). Its sense bit follows after edge k+1, and its flag and `turn_on` after edge k+2. An alarm or restart change gives `turn_on` after edge k itself. The latency checks count exactly those rising edges and sample 1 ns after the expected edge. Pulse-count and source checks wait four or more cycles, sample on the falling edge, and compare against a falling-edge monitor that counts every pulse. This lets them confirm that each stimulus produced exactly zero or one pulse.

// File: rtl/wq_pkg.sv
`timescale 1ns/1ps
package wq_pkg;
  localparam int NSRC = 5;
  localparam int SRC_W = 3;

  // index order of the event vector is the priority order (0 highest)
  localparam int IX_BATT    = 0;
  localparam int IX_CHG     = 1;
  localparam int IX_USB     = 2;
  localparam int IX_ALARM   = 3;
  localparam int IX_RESTART = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE    = 3'd0,
    SRC_BATT    = 3'd1,
    SRC_CHG     = 3'd2,
    SRC_USB     = 3'd3,
    SRC_ALARM   = 3'd4,
    SRC_RESTART = 3'd5
  } wake_src_e;
endpackage

// File: rtl/wq_sync.sv
`timescale 1ns/1ps
module wq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wq_detect.sv
`timescale 1ns/1ps
module wq_detect #(
  parameter bit HAS_FLAG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic clr_i,
  output logic edge_o,
  output logic flag_o
);
  logic prev_q, prev_d;
  logic edge_w;

  assign edge_w = level_i & ~prev_q;
  assign prev_d = level_i;
  assign edge_o = edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

  generate
    if (HAS_FLAG) begin : g_flag
      logic flag_q, flag_d;

      // set has priority over a simultaneous clear
      always_comb begin
        flag_d = flag_q;
        if (clr_i)  flag_d = 1'b0;
        if (edge_w) flag_d = 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= flag_d;
      end

      assign flag_o = flag_q;

      // R3
      flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_w |=> flag_q);
      // R3
      flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !edge_w) |=> !flag_q);
      // R1
      flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !clr_i) |=> flag_q);
    end else begin : g_noflag
      logic unused_clr;
      assign unused_clr = clr_i;
      assign flag_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wq_arbiter.sv
`timescale 1ns/1ps
module wq_arbiter
  import wq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            batt_good_i,
  input  logic            sys_off_i,
  output logic            turn_on_o,
  output wake_src_e       src_o
);
  logic      turn_on_q, turn_on_d;
  wake_src_e src_q, src_d, pick;
  logic      fire;

  // lowest index wins
  always_comb begin
    pick = SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (evt_i[i]) pick = wake_src_e'(SRC_W'(i + 1));
    end
  end

  assign fire = sys_off_i && (|evt_i) && !turn_on_q;

  always_comb begin
    turn_on_d = fire;
    src_d     = src_q;
    if (fire) src_d = pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn_on_q <= 1'b0;
      src_q     <= SRC_NONE;
    end else begin
      turn_on_q <= turn_on_d;
      src_q     <= src_d;
    end
  end

  assign turn_on_o = turn_on_q;
  assign src_o     = src_q;

  // R8
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_on_q |=> !turn_on_q);
  // R8
  off_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_on_q |-> $past(sys_off_i));
  // R9
  src_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_on_q |-> (src_q != SRC_NONE));
  // R9
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !turn_on_q |-> $stable(src_q));
  // R4
  batt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (turn_on_q && src_q != SRC_BATT) |-> $past(batt_good_i));
endmodule

// File: rtl/wake_qualifier.sv
`timescale 1ns/1ps
module wake_qualifier
  import wq_pkg::*;
#(
  parameter int TOD_W = 17,
  parameter int DAY_W = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_det_a,
  input  logic             usb_det_a,
  input  logic             batt_ok_a,
  input  logic [TOD_W-1:0] tod_cnt,
  input  logic [TOD_W-1:0] tod_alarm,
  input  logic [DAY_W-1:0] day_cnt,
  input  logic [DAY_W-1:0] day_alarm,
  input  logic             restart_req,
  input  logic             restart_en,
  input  logic             sys_off,
  input  logic [1:0]       irq_clr,
  output logic             chg_irq,
  output logic             usb_irq,
  output logic             chg_sense,
  output logic             usb_sense,
  output logic             turn_on,
  output logic [2:0]       wake_src
);
  localparam int NASYNC = 3;

  logic              rst_sync_n;
  logic [NASYNC-1:0] async_s;
  logic              batt_s;
  logic              alarm_match;
  logic [NSRC-1:0]   level, clr_vec, edge_v, flag_v, evt;
  wake_src_e         src;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  wq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i (clk),
    .rst_ni(rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  wq_sync #(.WIDTH(NASYNC), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i (clk),
    .rst_ni(rst_sync_n),
    .d_i   ({usb_det_a, chg_det_a, batt_ok_a}),
    .q_o   (async_s)
  );

  assign batt_s      = async_s[0];
  assign alarm_match = (tod_cnt == tod_alarm) && (day_cnt == day_alarm);

  always_comb begin
    level               = '0;
    level[IX_BATT]      = async_s[0];
    level[IX_CHG]       = async_s[1];
    level[IX_USB]       = async_s[2];
    level[IX_ALARM]     = alarm_match;
    level[IX_RESTART]   = restart_req;
    clr_vec             = '0;
    clr_vec[IX_CHG]     = irq_clr[0];
    clr_vec[IX_USB]     = irq_clr[1];
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_det
      wq_detect #(.HAS_FLAG(g == IX_CHG || g == IX_USB)) u_det (
        .clk_i  (clk),
        .rst_ni (rst_sync_n),
        .level_i(level[g]),
        .clr_i  (clr_vec[g]),
        .edge_o (edge_v[g]),
        .flag_o (flag_v[g])
      );
    end
  endgenerate

  // qualification by the battery level
  always_comb begin
    evt              = '0;
    evt[IX_BATT]     = edge_v[IX_BATT];
    evt[IX_CHG]      = edge_v[IX_CHG]     & batt_s;
    evt[IX_USB]      = edge_v[IX_USB]     & batt_s;
    evt[IX_ALARM]    = edge_v[IX_ALARM]   & batt_s;
    evt[IX_RESTART]  = edge_v[IX_RESTART] & batt_s & restart_en;
  end

  wq_arbiter u_arb (
    .clk_i      (clk),
    .rst_ni     (rst_sync_n),
    .evt_i      (evt),
    .batt_good_i(batt_s),
    .sys_off_i  (sys_off),
    .turn_on_o  (turn_on),
    .src_o      (src)
  );

  assign wake_src  = src;
  assign chg_irq   = flag_v[IX_CHG];
  assign usb_irq   = flag_v[IX_USB];
  assign chg_sense = async_s[1];
  assign usb_sense = async_s[2];

  logic unused_flags;
  assign unused_flags = |{flag_v[IX_BATT], flag_v[IX_ALARM], flag_v[IX_RESTART]};

  // R6
  alarm_both_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (turn_on && wake_src == SRC_ALARM) |->
      $past((tod_cnt == tod_alarm) && (day_cnt == day_alarm)));
  // R7
  restart_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (turn_on && wake_src == SRC_RESTART) |-> $past(restart_en));
endmodule

// File: tb/wake_qualifier_tb_top.sv
`timescale 1ns/1ps
module wake_qualifier_tb_top;
  localparam int TOD_W = 17;
  localparam int DAY_W = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             chg_det_a, usb_det_a, batt_ok_a;
  logic [TOD_W-1:0] tod_cnt, tod_alarm;
  logic [DAY_W-1:0] day_cnt, day_alarm;
  logic             restart_req, restart_en, sys_off;
  logic [1:0]       irq_clr;
  logic             chg_irq, usb_irq, chg_sense, usb_sense, turn_on;
  logic [2:0]       wake_src;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  int base = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_qualifier #(.TOD_W(TOD_W), .DAY_W(DAY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chg_det_a(chg_det_a), .usb_det_a(usb_det_a),
    .batt_ok_a(batt_ok_a), .tod_cnt(tod_cnt), .tod_alarm(tod_alarm),
    .day_cnt(day_cnt), .day_alarm(day_alarm), .restart_req(restart_req),
    .restart_en(restart_en), .sys_off(sys_off), .irq_clr(irq_clr),
    .chg_irq(chg_irq), .usb_irq(usb_irq), .chg_sense(chg_sense),
    .usb_sense(usb_sense), .turn_on(turn_on), .wake_src(wake_src)
  );

  // counts every turn-on pulse, sampled away from the rising edge
  always @(negedge clk) if (turn_on) pulse_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulses_since(input string req, input int exp);
    chk(req, pulse_cnt - base, exp);
    base = pulse_cnt;
  endtask

  task automatic t_reset();
    chk("R10 turn_on reset", int'(turn_on), 0);
    chk("R10 wake_src reset", int'(wake_src), 0);
    chk("R10 chg_irq reset", int'(chg_irq), 0);
    chk("R10 usb_irq reset", int'(usb_irq), 0);
  endtask

  task automatic t_batt();
    base = pulse_cnt;
    batt_ok_a = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R10 async latency", int'(turn_on), 1);
    @(posedge clk);
    #1 chk("R8 single cycle", int'(turn_on), 0);
    tick(3);
    pulses_since("R5 battery wake", 1);
    chk("R5 src battery", int'(wake_src), 1);
  endtask

  task automatic t_chg();
    chg_det_a = 1'b1;
    tick(4);
    pulses_since("R1 charger wake", 1);
    chk("R9 src charger", int'(wake_src), 2);
    chk("R1 chg_irq set", int'(chg_irq), 1);
    chk("R1 chg_sense high", int'(chg_sense), 1);
    chg_det_a = 1'b0;
    tick(4);
    chk("R1 chg_sense low", int'(chg_sense), 0);
    chk("R1 chg_irq sticky", int'(chg_irq), 1);
    pulses_since("R1 falling no wake", 0);
  endtask

  task automatic t_clear();
    irq_clr = 2'b01;
    tick(1);
    irq_clr = 2'b00;
    tick(1);
    chk("R3 clear chg", int'(chg_irq), 0);
    // re-set, then collide a clear with a new set
    chg_det_a = 1'b1;
    tick(4);
    chg_det_a = 1'b0;
    tick(4);
    chg_det_a = 1'b1;        // sampled at edge k
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    irq_clr = 2'b01;         // present at edge k+2, the set edge
    @(posedge clk); @(negedge clk);
    irq_clr = 2'b00;
    tick(1);
    chk("R3 set wins over clear", int'(chg_irq), 1);
    chg_det_a = 1'b0;
    irq_clr = 2'b01;
    tick(1);
    irq_clr = 2'b00;
    tick(3);
    chk("R3 cleared again", int'(chg_irq), 0);
    base = pulse_cnt;
  endtask

  task automatic t_usb();
    usb_det_a = 1'b1;
    tick(4);
    pulses_since("R2 usb wake", 1);
    chk("R9 src usb", int'(wake_src), 3);
    chk("R2 usb_irq set", int'(usb_irq), 1);
    chk("R2 usb_sense high", int'(usb_sense), 1);
    usb_det_a = 1'b0;
    tick(4);
    chk("R2 usb_sense low", int'(usb_sense), 0);
    chk("R2 usb_irq sticky", int'(usb_irq), 1);
    irq_clr = 2'b10;
    tick(1);
    irq_clr = 2'b00;
    tick(1);
    chk("R3 clear usb", int'(usb_irq), 0);
  endtask

  task automatic t_lowbatt();
    batt_ok_a = 1'b0;
    tick(4);
    base = pulse_cnt;
    chg_det_a = 1'b1;
    usb_det_a = 1'b1;
    tick(5);
    pulses_since("R4 low battery blocks", 0);
    chk("R4 src unchanged", int'(wake_src), 3);
    chk("R4 chg_irq still set", int'(chg_irq), 1);
    chk("R4 usb_irq still set", int'(usb_irq), 1);
    chg_det_a = 1'b0;
    usb_det_a = 1'b0;
    irq_clr = 2'b11;
    tick(1);
    irq_clr = 2'b00;
    tick(4);
  endtask

  task automatic t_alarm();
    batt_ok_a = 1'b1;
    tick(5);
    pulses_since("R5 battery return", 1);
    tod_cnt = 17'd500; tod_alarm = 17'd500;
    day_cnt = 15'd3;   day_alarm = 15'd9;
    tick(3);
    pulses_since("R6 only tod match", 0);
    day_cnt = 15'd9;
    @(posedge clk);
    #1 chk("R10 sync latency", int'(turn_on), 1);
    tick(2);
    pulses_since("R6 alarm wake", 1);
    chk("R9 src alarm", int'(wake_src), 4);
    tod_alarm = 17'd1;
    tick(2);
  endtask

  task automatic t_restart();
    restart_en = 1'b0;
    restart_req = 1'b1;
    tick(1);
    restart_req = 1'b0;
    tick(3);
    pulses_since("R7 restart disabled", 0);
    chk("R7 src unchanged", int'(wake_src), 4);
    restart_en = 1'b1;
    restart_req = 1'b1;
    tick(1);
    restart_req = 1'b0;
    tick(3);
    pulses_since("R7 restart enabled", 1);
    chk("R7 src restart", int'(wake_src), 5);
  endtask

  task automatic t_prio();
    chg_det_a = 1'b1;
    usb_det_a = 1'b1;
    tick(5);
    pulses_since("R9 chg+usb one pulse", 1);
    chk("R9 chg over usb", int'(wake_src), 2);
    tod_alarm = 17'd500;     // alarm and restart together
    restart_req = 1'b1;
    tick(1);
    restart_req = 1'b0;
    tick(3);
    pulses_since("R9 alarm+restart one pulse", 1);
    chk("R9 alarm over restart", int'(wake_src), 4);
    tod_alarm = 17'd1;
    chg_det_a = 1'b0;
    batt_ok_a = 1'b0;
    tick(5);
    base = pulse_cnt;
    chg_det_a = 1'b1;
    batt_ok_a = 1'b1;
    tick(5);
    pulses_since("R9 batt+chg one pulse", 1);
    chk("R9 battery over charger", int'(wake_src), 1);
    chg_det_a = 1'b0;
    usb_det_a = 1'b0;
    tick(4);
  endtask

  task automatic t_sys_on();
    irq_clr = 2'b11;
    tick(1);
    irq_clr = 2'b00;
    sys_off = 1'b0;
    base = pulse_cnt;
    usb_det_a = 1'b1;
    tick(5);
    pulses_since("R8 no pulse while on", 0);
    chk("R8 src unchanged", int'(wake_src), 1);
    chk("R2 irq while on", int'(usb_irq), 1);
    usb_det_a = 1'b0;
    sys_off = 1'b1;
    tick(4);
  endtask

  initial begin
    rst_n = 1'b0;
    chg_det_a = 1'b0; usb_det_a = 1'b0; batt_ok_a = 1'b0;
    tod_cnt = '0; tod_alarm = 17'd1; day_cnt = '0; day_alarm = '0;
    restart_req = 1'b0; restart_en = 1'b0; sys_off = 1'b1; irq_clr = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_batt();
    t_chg();
    t_clear();
    t_usb();
    t_lowbatt();
    t_alarm();
    t_restart();
    t_prio();
    t_sys_on();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule